// File: doc/BRIEF.md
# UART Receive Queue with Programmable Threshold

This block holds received UART characters in a 64-deep, byte-wide queue until the host collects them. It compares the fill level with a programmable threshold and raises a threshold flag. A receiver front end pushes each deserialized byte, and the host pops bytes from the head. The host programs three registers over a small register write bus: a queue control register, a level register and an auxiliary register.

The threshold comes from one of three sources. The first is a coarse two-bit code held in the control register. The second is an override held in the upper nibble of the level register. The third is a fine six-bit value that joins the level register nibble with the coarse code bits. Some control register fields accept a write only under conditions seen at the inputs: the enhanced-feature enable for one field, and a stopped baud divisor for another.

When the queue is switched off, the block acts as a single holding register that uses only location 0. An overfilled queue drops the incoming byte and latches an overrun flag, which a host status read clears.

Top module: `rxq_trigger`

## Requirements
- R1: After reset `empty` is 1, `level` is 0, `trigger` is 0, `overrun` is 0 and `ctlValue` is 0x00, so queue mode is off.
- R2: With `ctlValue[0]`=1 the queue holds up to 64 bytes and returns them in arrival order; `level` gives the count and `empty` is high exactly when the count is 0.
- R3: When aux bit 7 is 0 and level-register bits 7:4 are 0000, `ctlValue[7:6]` selects the threshold: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60.
- R4: When aux bit 7 is 0 and level-register bits 7:4 are nonzero, the threshold is that nibble times 4, and `ctlValue[7:6]` has no effect on it.
- R5: When aux bit 7 is 1, the threshold is the six-bit value {level-register bits 7:4, `ctlValue[7:6]`}, and a result of 0 is used as 1.
- R6: In queue mode `trigger` is high exactly while `level` is at or above the threshold, and it follows `level` in the same cycle after the push or pop edge.
- R7: A control register write (regSel=0) updates bits 5:4 only while `enhanceEn` is 1; otherwise those bits keep their value.
- R8: A control register write updates bits 3:0 only while `baudDiv` is zero; bits 7:6 are always written.
- R9: With `ctlValue[0]`=0 only location 0 is used: capacity is one byte and `trigger` is high whenever that byte is present. An accepted change of bit 0 empties the queue.
- R10: A push while the queue is full is dropped and sets a sticky `overrun`. A `statusRd` pulse clears `overrun`, and a new drop in the same cycle takes precedence over the clear.
- R11: A pop while the queue is empty leaves `rdData` and `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 1 | Receiver byte strobe |
| pushData | input | 8 | Received byte |
| popEn | input | 1 | Host read strobe |
| rdData | output | 8 | Byte popped most recently, valid the cycle after the pop |
| statusRd | input | 1 | Host status read, clears overrun |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | 0 control, 1 level, 2 auxiliary |
| regWdata | input | 8 | Register write data |
| enhanceEn | input | 1 | Enhanced-feature enable, gates control bits 5:4 |
| baudDiv | input | 16 | Current baud divisor; zero means stopped |
| ctlValue | output | 8 | Current control register contents |
| empty | output | 1 | Queue holds no byte |
| level | output | 7 | Number of bytes held |
| trigger | output | 1 | Level at or above the active threshold |
| overrun | output | 1 | Sticky dropped-byte flag |

## Verification
A corrupt pointer or count appears at `rdData` as bytes out of order or duplicated on the next pop, or as a `level` that disagrees with the number of pushes minus the number of pops. A wrong source choice or wrong arithmetic in the threshold select shows up at `trigger` on the push that crosses the expected threshold, one cycle after the push strobe. A faulty write gate shows up at `ctlValue` in the cycle after the write. A queue that stays live through a mode change shows up at once as a nonzero `level`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic fifoOn;
  } rxq_cmd_t;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_LVL = 2'd1;
  localparam logic [1:0] SEL_AUX = 2'd2;

  localparam int THR_W = 6;
  localparam logic [THR_W-1:0] COARSE_T0 = 6'd8;
  localparam logic [THR_W-1:0] COARSE_T1 = 6'd16;
  localparam logic [THR_W-1:0] COARSE_T2 = 6'd56;
  localparam logic [THR_W-1:0] COARSE_T3 = 6'd60;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxq_cmd_t      cmd,
  input  logic [DW-1:0] pushData,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          dropped
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] capacity;
  logic          full, pushOk, popOk;

  assign capacity = cmd.fifoOn ? CW'(DEPTH) : CW'(1);
  assign full     = (count >= capacity);
  assign empty    = (count == '0);
  assign pushOk   = cmd.push && !full && !cmd.flush;
  assign popOk    = cmd.pop && !empty && !cmd.flush;
  assign dropped  = cmd.push && full && !cmd.flush;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p, input logic on);
    if (!on) return '0;
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= stepPtr(wrPtr, cmd.fifoOn);
      if (popOk) begin
        rdData <= mem[rdPtr];
        rdPtr  <= stepPtr(rdPtr, cmd.fifoOn);
      end
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  // R2: the count never exceeds the storage depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  // R9: with queue mode off at most one byte is held
  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.fifoOn |-> count <= CW'(1));
  // R10: a dropped push leaves the count alone
  a_r10_drop_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (dropped && !cmd.pop) |=> count == $past(count));
  // R11: a pop from an empty queue leaves rdData alone
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pop && empty && !cmd.flush) |=> $stable(rdData));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushEn,
  input  logic          popEn,
  input  logic          statusRd,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [7:0]    regWdata,
  input  logic          enhanceEn,
  input  logic [15:0]   baudDiv,
  input  logic [CW-1:0] count,
  input  logic          dropped,
  output rxq_cmd_t      cmd,
  output logic [7:0]    ctlReg,
  output logic          trigger,
  output logic          overrun
);
  logic [3:0]       lvlHi;
  logic             fineMode;
  logic             ctlWr, lowOk;
  logic [7:0]       ctlNext;
  logic [THR_W-1:0] threshold, fineThr, coarseThr;

  assign ctlWr = regWe && (regSel == SEL_CTL);
  assign lowOk = (baudDiv == 16'd0);

  always_comb begin
    ctlNext      = ctlReg;
    ctlNext[7:6] = regWdata[7:6];
    if (enhanceEn) ctlNext[5:4] = regWdata[5:4];
    if (lowOk)     ctlNext[3:0] = regWdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg   <= 8'h00;
      lvlHi    <= 4'h0;
      fineMode <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (ctlWr) ctlReg <= ctlNext;
      if (regWe && regSel == SEL_LVL) lvlHi <= regWdata[7:4];
      if (regWe && regSel == SEL_AUX) fineMode <= regWdata[7];
      if (dropped)       overrun <= 1'b1;
      else if (statusRd) overrun <= 1'b0;
    end
  end

  always_comb begin
    unique case (ctlReg[7:6])
      2'b00:   coarseThr = COARSE_T0;
      2'b01:   coarseThr = COARSE_T1;
      2'b10:   coarseThr = COARSE_T2;
      default: coarseThr = COARSE_T3;
    endcase
    fineThr = {lvlHi, ctlReg[7:6]};
    if (fineMode)            threshold = (fineThr == '0) ? THR_W'(1) : fineThr;
    else if (lvlHi != 4'h0)  threshold = {lvlHi, 2'b00};
    else                     threshold = coarseThr;
  end

  assign cmd.push   = pushEn;
  assign cmd.pop    = popEn;
  assign cmd.fifoOn = ctlReg[0];
  assign cmd.flush  = ctlWr && (ctlNext[0] != ctlReg[0]);

  assign trigger = ctlReg[0] ? (count >= CW'(threshold)) : (count != '0);

  // R7: bits 5:4 hold when the enhanced enable is low
  a_r7_gate_hi: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !enhanceEn) |=> ctlReg[5:4] == $past(ctlReg[5:4]));
  // R8: bits 3:0 hold while the divisor runs
  a_r8_gate_lo: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !lowOk) |=> ctlReg[3:0] == $past(ctlReg[3:0]));
  // R10: a drop always leaves the sticky flag set
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dropped |=> overrun);
  // R9: a mode change empties the queue
  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> count == '0);
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushEn,
  input  logic [DW-1:0] pushData,
  input  logic          popEn,
  output logic [DW-1:0] rdData,
  input  logic          statusRd,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [7:0]    regWdata,
  input  logic          enhanceEn,
  input  logic [15:0]   baudDiv,
  output logic [7:0]    ctlValue,
  output logic          empty,
  output logic [CW-1:0] level,
  output logic          trigger,
  output logic          overrun
);
  rxq_cmd_t cmd;
  logic     dropped;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .pushEn, .popEn, .statusRd, .regWe, .regSel, .regWdata,
    .enhanceEn, .baudDiv, .count(level), .dropped, .cmd,
    .ctlReg(ctlValue), .trigger, .overrun
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk, .rstN, .cmd, .pushData, .rdData, .count(level), .empty, .dropped
  );
endmodule

// File: tb/rxq_trigger_tb.sv
module rxq_trigger_tb;
  logic clk = 0, rstN = 0;
  logic pushEn = 0, popEn = 0, statusRd = 0, regWe = 0, enhanceEn = 0;
  logic [7:0] pushData = 0, regWdata = 0;
  logic [1:0] regSel = 0;
  logic [15:0] baudDiv = 0;
  logic [7:0] rdData, ctlValue;
  logic empty, trigger, overrun;
  logic [6:0] level;
  int checks = 0, fails = 0;
  logic [7:0] expCtl = 0;

  always #5 clk = ~clk;

  rxq_trigger u_dut (
    .clk, .rstN, .pushEn, .pushData, .popEn, .rdData, .statusRd, .regWe,
    .regSel, .regWdata, .enhanceEn, .baudDiv, .ctlValue, .empty, .level,
    .trigger, .overrun
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] val);
    regWe = 1; regSel = sel; regWdata = val;
    if (sel == 2'd0) begin
      expCtl[7:6] = val[7:6];
      if (enhanceEn) expCtl[5:4] = val[5:4];
      if (baudDiv == 0) expCtl[3:0] = val[3:0];
    end
    @(negedge clk); regWe = 0;
  endtask

  task automatic push(input logic [7:0] b);
    pushEn = 1; pushData = b; @(negedge clk); pushEn = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    popEn = 1; @(negedge clk); popEn = 0; b = rdData;
  endtask

  task automatic pushN(input int n, input int base);
    for (int i = 0; i < n; i++) push(8'(base + i));
  endtask

  task automatic drain();
    logic [7:0] d;
    while (level != 0) pop(d);
  endtask

  task automatic t_reset();
    check("R1 empty", empty, 1); check("R1 level", level, 0);
    check("R1 trigger", trigger, 0); check("R1 overrun", overrun, 0);
    check("R1 ctl", ctlValue, 0);
  endtask

  task automatic t_order();
    logic [7:0] d;
    regWrite(2'd0, 8'h01);
    check("R2 enable", ctlValue, 1);
    for (int i = 0; i < 64; i++) push(8'(i * 3 + 1));
    check("R2 level full", level, 64); check("R2 not empty", empty, 0);
    for (int i = 0; i < 64; i++) begin
      pop(d); check("R2 order", d, (i * 3 + 1) & 255);
    end
    check("R2 empty after", empty, 1);
  endtask

  task automatic t_coarse();
    logic [7:0] d;
    int thr;
    for (int c = 0; c < 4; c++) begin
      thr = (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 56 : 60;
      regWrite(2'd0, {2'(c), 6'b000001});
      pushN(thr - 1, 10);
      check("R3 below", trigger, 0);
      push(8'h55);
      check("R3 at threshold", trigger, 1); check("R6 level", level, thr);
      pop(d);
      check("R6 falls same cycle", trigger, 0);
      drain();
    end
  endtask

  task automatic t_override();
    regWrite(2'd0, 8'hC1);
    regWrite(2'd1, 8'h30);
    pushN(11, 0); check("R4 below 12", trigger, 0);
    push(8'h01); check("R4 at 12", trigger, 1);
    drain(); regWrite(2'd1, 8'h00);
  endtask

  task automatic t_fine();
    regWrite(2'd2, 8'h80);
    regWrite(2'd1, 8'h20);
    regWrite(2'd0, 8'h41);
    pushN(8, 0); check("R5 below 9", trigger, 0);
    push(8'h01); check("R5 at 9", trigger, 1);
    drain();
    regWrite(2'd1, 8'h00); regWrite(2'd0, 8'h01);
    check("R5 zero empty", trigger, 0);
    push(8'h07); check("R5 zero as one", trigger, 1);
    drain(); regWrite(2'd2, 8'h00);
  endtask

  task automatic t_gates();
    enhanceEn = 0; regWrite(2'd0, 8'h31);
    check("R7 gated hi", ctlValue, expCtl);
    enhanceEn = 1; regWrite(2'd0, 8'h31);
    check("R7 open hi", ctlValue, expCtl);
    enhanceEn = 0;
    baudDiv = 16'h0010; regWrite(2'd0, 8'h80);
    check("R8 gated lo", ctlValue, expCtl);
    pushN(2, 0); check("R8 still queue", level, 2);
    drain();
    baudDiv = 0; regWrite(2'd0, 8'h01);
    check("R8 open lo", ctlValue, expCtl);
  endtask

  task automatic t_single();
    logic [7:0] d;
    pushN(3, 0);
    regWrite(2'd0, 8'h00);
    check("R9 flush", level, 0);
    push(8'hA5); check("R9 level", level, 1); check("R9 trigger", trigger, 1);
    push(8'h5A); check("R9 capacity", level, 1); check("R10 single drop", overrun, 1);
    pop(d); check("R9 data", d, 8'hA5);
    statusRd = 1; @(negedge clk); statusRd = 0;
    check("R10 clear", overrun, 0);
    regWrite(2'd0, 8'h01);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    pushN(64, 100);
    push(8'hFF);
    check("R10 level", level, 64); check("R10 sticky", overrun, 1);
    @(negedge clk); check("R10 holds", overrun, 1);
    statusRd = 1; @(negedge clk); statusRd = 0;
    check("R10 cleared", overrun, 0);
    for (int i = 0; i < 64; i++) begin
      pop(d); check("R10 stored bytes", d, 100 + i);
    end
  endtask

  task automatic t_emptyPop();
    logic [7:0] d;
    pop(d);
    check("R11 data kept", d, 163); check("R11 level", level, 0);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);
    t_reset(); t_order(); t_coarse(); t_override(); t_fine();
    t_gates(); t_single(); t_overrun(); t_emptyPop();
    summary();
  end
endmodule